// File: doc/BRIEF.md
# Compare-Driven PWM Timer with Half-Cycle Edge Placement

This block is a 16-bit up-counter that produces a pulse-width-modulated signal on a complementary output pair. It uses two compare values. The second compare value sets the period, because the counter returns to zero after it matches. The first compare value sets the point in the period where the output leaves its start level. Each match also raises a single-cycle flag, and a surrounding interrupt controller can use these flags as interrupt causes.

The start level is the exclusive-or of a level-select bit and a polarity-invert bit. The pair holds this level whenever the output enable is low, and also after a counter clear. In the optional fine mode, every compare works on the value halved. Bit 0 of the first compare value then chooses one of two edges for the activation: the rising edge of the count clock, or the falling edge half a cycle later. This gives the duty cycle a resolution of half a count clock.

Top module: `pwm_fine_timer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter, the output state and both flags clear. `tout` then equals the start level and both flags read 0.
- R2: The start level is `lvl_sel ^ pol_inv`: 00 gives 0, 01 gives 1, 10 gives 1, 11 gives 0. While `out_en` is 0, `tout` equals the start level whatever the counter is doing.
- R3: The counter advances by one per count clock only while `run` is 1. With `run` at 0, the count, the output and the flags hold and no flag fires.
- R4: In normal mode, when the count equals `cmp_b` on an advancing edge, the next count is 0. `flag_b` is then 1 for exactly the one cycle that follows, so the period is `cmp_b`+1 clocks.
- R5: When the effective A value is less than the effective B value, the output state is active (`tout` = NOT start level, with `out_en`=1) during every count at or above A. `flag_a` is 1 for the one cycle in which the count first equals A. With A=3 and B=5 the active counts are 3, 4 and 5, out of a period of 6.
- R6: When the effective A value is greater than or equal to the effective B value, the output never becomes active and `flag_a` never fires.
- R7: A cycle with `cnt_clr` at 1 sets the count to 0, returns `tout` to the start level and clears both flags on the next edge.
- R8: With `fine` at 1, the count's low 15 bits are compared with `cmp_a[15:1]` and `cmp_b[15:1]`. The period is `cmp_b[15:1]`+1 whole clocks.
- R9: With `fine` at 1 and `cmp_a[0]` at 1, the activation of `tout` moves to the falling clock edge that follows the rising edge where it would otherwise happen. The return to the start level stays on the rising edge.
- R10: `toutn` is always the inverse of `tout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_clr | input | 1 | Clears counter and output state |
| run | input | 1 | Counter advance enable |
| out_en | input | 1 | Output waveform enable |
| cmp_a | input | 16 | Compare value for the activation point |
| cmp_b | input | 16 | Compare value for the period end |
| fine | input | 1 | Halved compare with half-cycle edge select |
| lvl_sel | input | 1 | Start level select |
| pol_inv | input | 1 | Polarity invert |
| tout | output | 1 | PWM output |
| toutn | output | 1 | Inverse of `tout` |
| flag_a | output | 1 | One-cycle pulse on compare-A match |
| flag_b | output | 1 | One-cycle pulse on period wrap |

## Verification
The hardest case to reach from the ports is the half-cycle activation in fine mode. It can only be observed between two rising edges, and the rising-edge output state already looks correct there. The bench samples the outputs twice per clock, a quarter period after each edge. It counts the periods in which `tout` shows the start level just after the rising edge and the active level just after the falling edge. It expects one such period per cycle of the waveform when `cmp_a[0]` is set, and none in normal mode or with an even `cmp_a`. A behavioural model compares the outputs at every sample point while the stimulus moves through polarity combinations, stalls, clears, degenerate compare values and a sweep of A/B pairs.

// File: rtl/pwm_fine_pkg.sv
// Shared types for the PWM timer.
// Assumes: nothing beyond standard SystemVerilog.
package pwm_fine_pkg;

    // Which count-clock edge moves the output into its active state.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } act_edge_e;

endpackage

// File: rtl/pwm_tick_counter.sv
// Up-counter that wraps to zero when it matches the period compare value.
// In fine mode the compare uses the halved period value against the low
// CNT_W-1 count bits. The next-count value is exported so that downstream
// state can be registered in step with the count.
// Assumes: cnt_clr has priority over run; rst_n is synchronous.
module pwm_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             run,
    input  logic             fine,
    input  logic [CNT_W-1:0] cmp_b,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);
    localparam int HALF_W = CNT_W - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_eff;
    logic [CNT_W-1:0] b_eff;

    // Effective count and period values for the selected resolution.
    always_comb begin
        cnt_eff = fine ? {1'b0, cnt_q[HALF_W-1:0]} : cnt_q;
        b_eff   = fine ? {1'b0, cmp_b[CNT_W-1:1]} : cmp_b;
    end

    // Wrap detection and next-count selection.
    always_comb begin
        wrap = run && (cnt_eff == b_eff);
        if (!run)
            cnt_nxt = cnt_q;
        else if (wrap)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt_q + 1'b1;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !run) |=> (cnt_q == $past(cnt_q)));

    // R4
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && wrap) |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_compare_unit.sv
// Registers the output state and the two match flags from the next count,
// so the state lines up with the count it belongs to. Compare A only acts
// when its effective value is below the effective period value.
// Assumes: cnt_nxt and wrap come from pwm_tick_counter in the same cycle.
module pwm_compare_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             run,
    input  logic             fine,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             wrap,
    output logic             act_q,
    output logic             flag_a_q,
    output logic             flag_b_q
);
    localparam int HALF_W = CNT_W - 1;

    logic [CNT_W-1:0] a_eff;
    logic [CNT_W-1:0] b_eff;
    logic [CNT_W-1:0] nxt_eff;
    logic             a_valid;

    // Effective compare operands for the selected resolution.
    always_comb begin
        a_eff   = fine ? {1'b0, cmp_a[CNT_W-1:1]} : cmp_a;
        b_eff   = fine ? {1'b0, cmp_b[CNT_W-1:1]} : cmp_b;
        nxt_eff = fine ? {1'b0, cnt_nxt[HALF_W-1:0]} : cnt_nxt;
        a_valid = a_eff < b_eff;
    end

    // Output state and one-cycle match flags.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr) begin
            act_q    <= 1'b0;
            flag_a_q <= 1'b0;
            flag_b_q <= 1'b0;
        end else begin
            act_q    <= a_valid && (nxt_eff >= a_eff);
            flag_a_q <= run && a_valid && (nxt_eff == a_eff);
            flag_b_q <= wrap;
        end
    end

    // R5
    flag_a_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_a_q |-> act_q);

    // R4
    flag_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_b_q |-> (!act_q || ($past(a_eff) == '0)));

    // R7
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (!act_q && !flag_a_q && !flag_b_q));

endmodule

// File: rtl/pwm_out_stage.sv
// Output stage: optionally delays the activation edge by half a clock using
// a falling-edge copy of the state, then applies enable and polarity.
// Assumes: act_q changes only on rising edges; the deactivation edge is
// never delayed because the AND drops as soon as act_q drops.
module pwm_out_stage
    import pwm_fine_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_q,
    input  logic half_dly,
    input  logic out_en,
    input  logic idle_lvl,
    output logic tout,
    output logic toutn
);
    act_edge_e edge_sel;
    logic      act_fall_q;
    logic      act_shaped;

    // Pick the activation edge from the fine-mode delay request.
    always_comb edge_sel = half_dly ? EDGE_FALL : EDGE_RISE;

    // Falling-edge copy of the rising-edge state.
    always_ff @(negedge clk) begin
        if (!rst_n)
            act_fall_q <= 1'b0;
        else
            act_fall_q <= act_q;
    end

    // Combine the copies so that only the activation edge is delayed.
    always_comb begin
        unique case (edge_sel)
            EDGE_FALL: act_shaped = act_q && act_fall_q;
            default:   act_shaped = act_q;
        endcase
    end

    // Enable gating and polarity.
    always_comb begin
        tout  = out_en ? (act_shaped ^ idle_lvl) : idle_lvl;
        toutn = ~tout;
    end

    // R9
    fall_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> act_fall_q);

endmodule

// File: rtl/pwm_fine_timer.sv
// PWM timer top: counter, compare unit and output stage.
// Assumes: compare values and mode bits are quasi-static, written by a
// register block outside; the count clock comes from an external prescaler.
module pwm_fine_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_clr,
    input  logic             run,
    input  logic             out_en,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             fine,
    input  logic             lvl_sel,
    input  logic             pol_inv,
    output logic             tout,
    output logic             toutn,
    output logic             flag_a,
    output logic             flag_b
);
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;
    logic             act_q;
    logic             idle_lvl;
    logic             half_dly;

    // Start level and half-cycle delay request.
    always_comb begin
        idle_lvl = lvl_sel ^ pol_inv;
        half_dly = fine && cmp_a[0];
    end

    pwm_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_clr (cnt_clr),
        .run     (run),
        .fine    (fine),
        .cmp_b   (cmp_b),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    pwm_compare_unit #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_clr  (cnt_clr),
        .run      (run),
        .fine     (fine),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .cnt_nxt  (cnt_nxt),
        .wrap     (wrap),
        .act_q    (act_q),
        .flag_a_q (flag_a),
        .flag_b_q (flag_b)
    );

    pwm_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_q    (act_q),
        .half_dly (half_dly),
        .out_en   (out_en),
        .idle_lvl (idle_lvl),
        .tout     (tout),
        .toutn    (toutn)
    );

endmodule

// File: tb/pwm_fine_timer_test.sv
// Bench: behavioural model compared at a quarter period after each edge.
module pwm_fine_timer_test;
    localparam int CLK_HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_clr = 1'b0;
    logic        run = 1'b0;
    logic        out_en = 1'b0;
    logic [15:0] cmp_a = 16'd0;
    logic [15:0] cmp_b = 16'd0;
    logic        fine = 1'b0;
    logic        lvl_sel = 1'b0;
    logic        pol_inv = 1'b0;
    logic        tout, toutn, flag_a, flag_b;

    int    n_chk = 0;
    int    n_err = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // model state
    int m_cnt = 0;
    bit m_act = 0, m_actn = 0, m_pa = 0, m_pb = 0;

    // window counters
    int w_pa = 0, w_pb = 0, w_act = 0, w_half = 0;

    always #(CLK_HALF) clk = ~clk;

    pwm_fine_timer uut (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .run(run),
        .out_en(out_en), .cmp_a(cmp_a), .cmp_b(cmp_b), .fine(fine),
        .lvl_sel(lvl_sel), .pol_inv(pol_inv),
        .tout(tout), .toutn(toutn), .flag_a(flag_a), .flag_b(flag_b)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural model of the count and the state at the rising edge.
    always @(posedge clk) begin
        int ae, be, ce, nx, ne;
        bit valid, wr;
        if (!rst_n || cnt_clr) begin
            m_cnt = 0; m_act = 0; m_pa = 0; m_pb = 0;
        end else begin
            ae = fine ? int'(cmp_a) / 2 : int'(cmp_a);
            be = fine ? int'(cmp_b) / 2 : int'(cmp_b);
            ce = fine ? m_cnt % 32768 : m_cnt;
            valid = ae < be;
            wr = run && (ce == be);
            if (!run) nx = m_cnt;
            else if (wr) nx = 0;
            else nx = (m_cnt + 1) % 65536;
            ne = fine ? nx % 32768 : nx;
            m_pb = wr;
            m_pa = run && valid && (ne == ae);
            m_act = valid && (ne >= ae);
            m_cnt = nx;
        end
    end

    // Falling-edge copy in the model.
    always @(negedge clk) m_actn = rst_n ? m_act : 1'b0;

    function automatic logic exp_tout();
        bit idle, shaped;
        idle = lvl_sel ^ pol_inv;
        shaped = m_act && ((fine && cmp_a[0]) ? m_actn : 1'b1);
        return out_en ? (shaped ^ idle) : idle;
    endfunction

    // Compare against the model a quarter period after each edge.
    always @(posedge clk) begin
        logic t_rise;
        #2;
        t_rise = tout;
        if (chk_en) begin
            chk(cur_req, "tout(rise)", tout, exp_tout());
            chk("R10", "toutn(rise)", toutn, ~tout);
            chk(cur_req, "flag_a", flag_a, m_pa);
            chk(cur_req, "flag_b", flag_b, m_pb);
            if (flag_a) w_pa++;
            if (flag_b) w_pb++;
        end
        #4;
        if (chk_en) begin
            chk(cur_req, "tout(fall)", tout, exp_tout());
            chk("R10", "toutn(fall)", toutn, ~tout);
            if (out_en && tout != (lvl_sel ^ pol_inv)) w_act++;
            if (out_en && t_rise == (lvl_sel ^ pol_inv) && tout != (lvl_sel ^ pol_inv)) w_half++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic win_clear();
        w_pa = 0; w_pb = 0; w_act = 0; w_half = 0;
    endtask

    task automatic restart();
        cnt_clr = 1'b1;
        cyc(1);
        cnt_clr = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        #(200000 * 2 * CLK_HALF);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cyc(2);
        chk_en = 1'b1;
        cur_req = "R1";
        chk("R1", "tout after reset", tout, 1'b0);
        chk("R1", "flag_a after reset", flag_a, 1'b0);
        chk("R1", "flag_b after reset", flag_b, 1'b0);
        rst_n = 1'b1;

        // R2: start level table with output disabled, counter running
        cur_req = "R2";
        cmp_a = 16'd1; cmp_b = 16'd3; run = 1'b1;
        for (int k = 0; k < 4; k++) begin
            lvl_sel = k[1]; pol_inv = k[0];
            cyc(5);
            chk("R2", "start level", tout, k[1] ^ k[0]);
            chk("R10", "inverse pair", toutn, ~(k[1] ^ k[0]));
        end

        // R5: A=3 B=5 waveform, active high
        cur_req = "R5";
        lvl_sel = 1'b0; pol_inv = 1'b0; cmp_a = 16'd3; cmp_b = 16'd5;
        out_en = 1'b1;
        restart();
        cyc(1);
        win_clear();
        cyc(12);
        chk_int("R5", "active samples in 12", w_act, 6);
        chk_int("R5", "flag_a count in 12", w_pa, 2);
        chk_int("R4", "flag_b count in 12", w_pb, 2);
        chk_int("R9", "half-cycle rises normal mode", w_half, 0);

        // R4: longer period with inverted polarity
        cur_req = "R4";
        lvl_sel = 1'b1; pol_inv = 1'b0; cmp_a = 16'd2; cmp_b = 16'd9;
        restart();
        cyc(1);
        win_clear();
        cyc(20);
        chk_int("R4", "flag_b count in 20", w_pb, 2);
        chk_int("R5", "active samples in 20", w_act, 16);

        // R3: stall
        cur_req = "R3";
        run = 1'b0;
        cyc(1);
        win_clear();
        cyc(8);
        chk_int("R3", "flags while stalled", w_pa + w_pb, 0);
        run = 1'b1;
        cyc(10);

        // R7: clear while active
        cur_req = "R7";
        lvl_sel = 1'b0; cmp_a = 16'd1; cmp_b = 16'd7;
        cyc(10);
        cnt_clr = 1'b1;
        cyc(1);
        chk("R7", "tout after clear", tout, 1'b0);
        chk("R7", "flag_b after clear", flag_b, 1'b0);
        cnt_clr = 1'b0;
        cyc(10);

        // R6: A not below B
        cur_req = "R6";
        cmp_a = 16'd5; cmp_b = 16'd5;
        restart();
        win_clear();
        cyc(12);
        chk_int("R6", "active samples A==B", w_act, 0);
        chk_int("R6", "flag_a count A==B", w_pa, 0);
        cmp_a = 16'd7; cmp_b = 16'd4;
        restart();
        win_clear();
        cyc(10);
        chk_int("R6", "active samples A>B", w_act, 0);
        chk_int("R6", "flag_a count A>B", w_pa, 0);

        // R8: fine mode, even A: same waveform as A=3 B=5
        cur_req = "R8";
        fine = 1'b1; cmp_a = 16'd6; cmp_b = 16'd10;
        restart();
        cyc(1);
        win_clear();
        cyc(12);
        chk_int("R8", "flag_b count fine", w_pb, 2);
        chk_int("R8", "active samples fine", w_act, 6);
        chk_int("R8", "half-cycle rises even A", w_half, 0);

        // R9: fine mode, odd A: activation on falling edge
        cur_req = "R9";
        cmp_a = 16'd7;
        restart();
        cyc(1);
        win_clear();
        cyc(12);
        chk_int("R9", "half-cycle rises odd A", w_half, 2);
        chk_int("R9", "active fall samples odd A", w_act, 6);
        chk_int("R9", "flag_a count odd A", w_pa, 2);
        pol_inv = 1'b1;
        cyc(14);
        fine = 1'b0; pol_inv = 1'b0;

        // R5: sweep of small A/B pairs and polarities
        cur_req = "R5";
        for (int a = 0; a < 5; a++) begin
            for (int b = 1; b < 6; b++) begin
                cmp_a = 16'(a); cmp_b = 16'(b);
                lvl_sel = a[0]; pol_inv = b[0];
                fine = (a + b) % 3 == 0;
                restart();
                cyc(14);
            end
        end
        fine = 1'b0;

        // R1: reset in mid-run
        cur_req = "R1";
        cmp_a = 16'd0; cmp_b = 16'd4; lvl_sel = 1'b0; pol_inv = 1'b0;
        cyc(7);
        rst_n = 1'b0;
        cyc(1);
        chk("R1", "tout after mid-run reset", tout, 1'b0);
        chk("R1", "flag_b after mid-run reset", flag_b, 1'b0);
        rst_n = 1'b1;
        cyc(10);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule